// File: doc/BRIEF.md
# Hit Pulse-Width Filter with Rate-Matching Buffer

This block is the per-channel front end that follows the time-capture logic of a timing channel. It watches a raw hit level sampled in the fast clock domain. It ignores any excursion of that level that does not last for a programmable number of cycles, and it recognises at most one edge per cycle. An accepted edge is either a rising (leading) edge or a falling (trailing) edge, and each kind can be enabled on its own. The block tags the edge with its polarity and with the timestamp of the cycle in which the raw change first appeared. It then writes the edge into a four-entry buffer.

The buffer absorbs bursts at the full fast rate. Its head is presented on the output at most once every four cycles, which matches a consumer that runs at a quarter of the fast clock. An edge that meets a full buffer is lost, and the loss is reported both as a one-cycle drop pulse and as a sticky overflow flag.

The filter is a two-state machine. STABLE holds the accepted level and waits for a difference. PEND counts how long the new level has lasted. The transitions are DETECT (STABLE to PEND when the raw level differs from the accepted level and the length is above one), INSTANT (STABLE to STABLE with an edge when the length is one), REJECT (PEND to STABLE when the raw level returns before the count completes) and CONFIRM (PEND to STABLE with an edge when the count reaches the length).

Top module: `hfe_channel`

## Requirements
- R1: After reset, out_valid_o, drop_o and ovf_o are low, and the accepted level is low, so the first accepted edge is a rising one.
- R2: A change of hit_i is accepted only after the new level has been present for L consecutive cycles, L being the effective filter length. Any excursion shorter than L produces no output record.
- R3: flt_len_i gives L in cycles. A value of 0 acts as 1, and any value above 13 acts as 13.
- R4: out_rise_o is 1 for a low-to-high edge and 0 for a high-to-low edge. An edge whose kind is disabled by lead_en_i or trail_en_i is not stored, but the filter's accepted level still follows it.
- R5: Records leave in the order they were accepted, with at least three idle cycles between any two out_valid_o pulses.
- R6: The buffer holds 4 records. An accepted, enabled edge that arrives while the buffer is full and no record leaves is lost. It raises drop_o for one cycle and sets ovf_o, which stays high until reset.
- R7: When the buffer is full and a record leaves in the same cycle as a new write, the new record is kept.
- R8: out_ts_o carries the ts_i value of the cycle in which the raw level first differed from the accepted level, not the value of the cycle that confirmed the edge.
- R9: With L equal to 1, a hit_i that toggles every cycle yields one edge per cycle, and no cycle yields more than one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | 1 | Raw hit level, sampled each cycle |
| ts_i | input | TS_W | Timestamp of the current cycle |
| flt_len_i | input | LEN_W | Filter length in cycles |
| lead_en_i | input | 1 | Store rising edges |
| trail_en_i | input | 1 | Store falling edges |
| out_valid_o | output | 1 | A record is on out_rise_o and out_ts_o this cycle |
| out_rise_o | output | 1 | Edge polarity of the record, 1 for rising |
| out_ts_o | output | TS_W | Timestamp of the record |
| ovf_o | output | 1 | Sticky flag: at least one record was lost |
| drop_o | output | 1 | One-cycle pulse for each lost record |

## Verification
On every cycle, the assertions check the following: the spacing between output records, that stored edges respect the polarity enables, that the overflow flag is sticky and set by each drop, and that a write to a full buffer in a read cycle is never dropped. The remaining behaviours need the bench's scenarios, because each depends on a history of stimulus. These are the pulse-width rejection at every filter length, the clamping of the length setting, the timestamp taken from the first cycle of a transition, the order of the records, and the exact number of records kept or lost in a burst of one edge per cycle.

// File: rtl/hfe_pkg.sv
package hfe_pkg;

    typedef enum logic [0:0] {
        FLT_STABLE = 1'b0,
        FLT_PEND   = 1'b1
    } flt_state_t;

    // Map the raw length setting onto the legal range 1..max_len.
    function automatic int unsigned clamp_len(input int unsigned raw, input int unsigned max_len);
        if (raw == 0)
            return 1;
        else if (raw > max_len)
            return max_len;
        else
            return raw;
    endfunction

endpackage

// File: rtl/hfe_glitch_filter.sv
module hfe_glitch_filter
    import hfe_pkg::*;
#(
    parameter int TS_W    = 16,
    parameter int LEN_W   = 4,
    parameter int LEN_MAX = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [TS_W-1:0]  ts_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             lead_en_i,
    input  logic             trail_en_i,
    output logic             wr_o,
    output logic             wr_rise_o,
    output logic [TS_W-1:0]  wr_ts_o
);

    localparam int CNT_W = LEN_W + 1;

    flt_state_t       state_q, state_d;
    logic             lvl_q, lvl_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [TS_W-1:0]  ts_q, ts_d;
    logic             confirm;
    logic [TS_W-1:0]  conf_ts;
    logic [CNT_W-1:0] eff_len;
    logic             kind_en;

    assign eff_len = CNT_W'(clamp_len(int'(len_i), LEN_MAX));
    assign kind_en = lvl_d ? lead_en_i : trail_en_i;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FLT_STABLE;
            lvl_q   <= 1'b0;
            cnt_q   <= '0;
            ts_q    <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
            cnt_q   <= cnt_d;
            ts_q    <= ts_d;
        end
    end

    // Next state and edge decision
    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        cnt_d   = cnt_q;
        ts_d    = ts_q;
        confirm = 1'b0;
        conf_ts = ts_q;
        unique case (state_q)
            FLT_STABLE: begin
                if (hit_i != lvl_q) begin
                    ts_d  = ts_i;
                    cnt_d = CNT_W'(1);
                    if (eff_len == CNT_W'(1)) begin
                        confirm = 1'b1;         // INSTANT
                        conf_ts = ts_i;
                        lvl_d   = hit_i;
                    end else begin
                        state_d = FLT_PEND;     // DETECT
                    end
                end
            end
            FLT_PEND: begin
                if (hit_i == lvl_q) begin
                    state_d = FLT_STABLE;       // REJECT
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_q + CNT_W'(1) >= eff_len) begin
                        confirm = 1'b1;         // CONFIRM
                        conf_ts = ts_q;
                        lvl_d   = hit_i;
                        state_d = FLT_STABLE;
                    end
                end
            end
            default: state_d = FLT_STABLE;
        endcase
    end

    // Registered edge output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_o      <= 1'b0;
            wr_rise_o <= 1'b0;
            wr_ts_o   <= '0;
        end else begin
            wr_o      <= confirm && kind_en;
            wr_rise_o <= lvl_d;
            wr_ts_o   <= conf_ts;
        end
    end

endmodule

// File: rtl/hfe_derand.sv
module hfe_derand #(
    parameter int W     = 17,
    parameter int DEPTH = 4,
    parameter int DIV   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic         rd_o,
    output logic         full_o,
    output logic         out_valid_o,
    output logic [W-1:0] out_data_o,
    output logic         drop_o,
    output logic         ovf_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] count_q;
    logic          stb;
    logic          wr_ok;

    // Drain strobe at 1/DIV of the clock rate
    generate
        if (DIV == 1) begin : g_stb_always
            assign stb = 1'b1;
        end else begin : g_stb_div
            logic [DW-1:0] phase_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    phase_q <= '0;
                else if (phase_q == DW'(DIV - 1))
                    phase_q <= '0;
                else
                    phase_q <= phase_q + DW'(1);
            end
            assign stb = (phase_q == DW'(DIV - 1));
        end
    endgenerate

    assign full_o = (count_q == CW'(DEPTH));
    assign rd_o   = stb && (count_q != '0);
    assign wr_ok  = wr_i && (!full_o || rd_o);

    function automatic logic [PW-1:0] nxt_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_ok)
            mem[wptr_q] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q      <= '0;
            rptr_q      <= '0;
            count_q     <= '0;
            out_valid_o <= 1'b0;
            out_data_o  <= '0;
            drop_o      <= 1'b0;
            ovf_o       <= 1'b0;
        end else begin
            if (wr_ok)
                wptr_q <= nxt_ptr(wptr_q);
            if (rd_o) begin
                rptr_q     <= nxt_ptr(rptr_q);
                out_data_o <= mem[rptr_q];
            end
            count_q     <= count_q + CW'(wr_ok) - CW'(rd_o);
            out_valid_o <= rd_o;
            drop_o      <= wr_i && !wr_ok;
            ovf_o       <= ovf_o || (wr_i && !wr_ok);
        end
    end

endmodule

// File: rtl/hfe_channel.sv
module hfe_channel #(
    parameter int TS_W      = 16,
    parameter int LEN_W     = 4,
    parameter int LEN_MAX   = 13,
    parameter int DEPTH     = 4,
    parameter int DRAIN_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [TS_W-1:0]  ts_i,
    input  logic [LEN_W-1:0] flt_len_i,
    input  logic             lead_en_i,
    input  logic             trail_en_i,
    output logic             out_valid_o,
    output logic             out_rise_o,
    output logic [TS_W-1:0]  out_ts_o,
    output logic             ovf_o,
    output logic             drop_o
);

    localparam int REC_W = TS_W + 1;

    logic             wr_w;
    logic             wr_rise_w;
    logic [TS_W-1:0]  wr_ts_w;
    logic             rd_w;
    logic             full_w;
    logic [REC_W-1:0] out_rec_w;

    hfe_glitch_filter #(
        .TS_W   (TS_W),
        .LEN_W  (LEN_W),
        .LEN_MAX(LEN_MAX)
    ) filt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit_i),
        .ts_i      (ts_i),
        .len_i     (flt_len_i),
        .lead_en_i (lead_en_i),
        .trail_en_i(trail_en_i),
        .wr_o      (wr_w),
        .wr_rise_o (wr_rise_w),
        .wr_ts_o   (wr_ts_w)
    );

    hfe_derand #(
        .W    (REC_W),
        .DEPTH(DEPTH),
        .DIV  (DRAIN_DIV)
    ) buf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_w),
        .wdata_i    ({wr_rise_w, wr_ts_w}),
        .rd_o       (rd_w),
        .full_o     (full_w),
        .out_valid_o(out_valid_o),
        .out_data_o (out_rec_w),
        .drop_o     (drop_o),
        .ovf_o      (ovf_o)
    );

    assign out_rise_o = out_rec_w[REC_W-1];
    assign out_ts_o   = out_rec_w[TS_W-1:0];

endmodule

// File: rtl/hfe_channel_chk.sv
module hfe_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic lead_en_i,
    input logic trail_en_i,
    input logic wr_w,
    input logic wr_rise_w,
    input logic rd_w,
    input logic full_w,
    input logic out_valid_o,
    input logic ovf_o,
    input logic drop_o
);

    AST_DRAIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (!$past(out_valid_o) && !$past(out_valid_o, 2) && !$past(out_valid_o, 3))); // R5

    AST_POLARITY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_w |-> (wr_rise_w ? $past(lead_en_i) : $past(trail_en_i))); // R4

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R6

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |-> ovf_o); // R6

    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_w && rd_w && full_w) |=> !drop_o); // R7

endmodule

bind hfe_channel hfe_channel_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lead_en_i  (lead_en_i),
    .trail_en_i (trail_en_i),
    .wr_w       (wr_w),
    .wr_rise_w  (wr_rise_w),
    .rd_w       (rd_w),
    .full_w     (full_w),
    .out_valid_o(out_valid_o),
    .ovf_o      (ovf_o),
    .drop_o     (drop_o)
);

// File: tb/hfe_channel_tb_top.sv
module hfe_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hit_i = 1'b0;
    logic [15:0] ts_i = '0;
    logic [3:0]  flt_len_i = 4'd1;
    logic        lead_en_i = 1'b1;
    logic        trail_en_i = 1'b1;
    logic        out_valid_o, out_rise_o, ovf_o, drop_o;
    logic [15:0] out_ts_o;

    always #2 clk = ~clk;

    hfe_channel dut_i (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .ts_i(ts_i),
        .flt_len_i(flt_len_i), .lead_en_i(lead_en_i), .trail_en_i(trail_en_i),
        .out_valid_o(out_valid_o), .out_rise_o(out_rise_o), .out_ts_o(out_ts_o),
        .ovf_o(ovf_o), .drop_o(drop_o)
    );

    int n_chk = 0, n_bad = 0;
    int exp_n = 0, got_n = 0, cmp_idx = 0, drops = 0;
    bit          exp_r [1024];
    logic [15:0] exp_t [1024];
    bit          got_r [1024];
    logic [15:0] got_t [1024];
    logic [15:0] tcnt = '0;
    bit mlvl = 1'b0;
    int effL = 1;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Output monitor, sampled at the falling edge
    int cyc = 0, last_v = -100;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (out_valid_o) begin
                check(cyc - last_v >= 4, "R5 output spacing", cyc - last_v, 4);
                last_v = cyc;
                if (got_n < 1024) begin
                    got_r[got_n] = out_rise_o;
                    got_t[got_n] = out_ts_o;
                    got_n++;
                end
            end
            if (drop_o) drops++;
        end
    end

    function automatic int eff_of(input int raw);
        return (raw == 0) ? 1 : (raw > 13 ? 13 : raw);
    endfunction

    task automatic set_len(input int raw);
        @(negedge clk);
        flt_len_i = 4'(raw);
        effL = eff_of(raw);
    endtask

    task automatic drive_seg(input bit v, input int len);
        logic [15:0] start_ts;
        start_ts = tcnt;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            hit_i = v;
            ts_i  = tcnt;
            tcnt  = tcnt + 16'd1;
        end
        if (v != mlvl && len >= effL) begin
            mlvl = v;
            if ((v && lead_en_i) || (!v && trail_en_i)) begin
                exp_r[exp_n] = v;
                exp_t[exp_n] = start_ts;
                exp_n++;
            end
        end
    endtask

    task automatic compare_exact(input string tag);
        repeat (40) @(negedge clk);
        check(got_n == exp_n, {tag, " record count"}, got_n, exp_n);
        for (int i = cmp_idx; i < exp_n && i < got_n; i++) begin
            check(got_r[i] == exp_r[i], {tag, " R4 polarity"}, got_r[i], exp_r[i]);
            check(got_t[i] == exp_t[i], {tag, " R8 timestamp"}, got_t[i], exp_t[i]);
        end
        if (got_n > exp_n) exp_n = got_n; else got_n = exp_n;
        cmp_idx = exp_n;
    endtask

    task automatic run_rand(input int nseg);
        bit cur;
        cur = mlvl;
        for (int k = 0; k < nseg; k++) begin
            cur = !cur;
            drive_seg(cur, (k == nseg - 1) ? 40 : 4 + int'($urandom % 17));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        hit_i = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mlvl = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int base, d0, kept;
        void'($urandom(32'd1234));
        do_reset();
        @(negedge clk);
        check(out_valid_o == 1'b0, "R1 valid after reset", out_valid_o, 0);
        check(ovf_o == 1'b0, "R1 ovf after reset", ovf_o, 0);
        check(drop_o == 1'b0, "R1 drop after reset", drop_o, 0);

        // R2 / R8: length 6, one short glitch then exact-length pulses
        set_len(6);
        drive_seg(1, 5); drive_seg(0, 8); drive_seg(1, 6); drive_seg(0, 6);
        drive_seg(1, 40);
        compare_exact("R2 directed L6");
        check(exp_n == 3 && exp_r[0] == 1'b1, "R1 first edge rising", exp_r[0], 1);

        // R3: setting 0 behaves as 1, setting 15 as 13
        set_len(0);
        drive_seg(0, 1); drive_seg(1, 5); drive_seg(0, 40);
        compare_exact("R3 len0");
        set_len(15);
        drive_seg(1, 12); drive_seg(0, 3); drive_seg(1, 13); drive_seg(0, 40);
        compare_exact("R3 len15");

        // R2 / R5 / R8: random lengths and pulse widths
        for (int r = 0; r < 4; r++) begin
            set_len(1 + int'($urandom % 13));
            run_rand(40);
            compare_exact("R2 random");
        end

        // R4: one polarity at a time
        @(negedge clk); lead_en_i = 1'b1; trail_en_i = 1'b0;
        set_len(3);
        run_rand(30);
        compare_exact("R4 lead only");
        @(negedge clk); lead_en_i = 1'b0; trail_en_i = 1'b1;
        run_rand(30);
        compare_exact("R4 trail only");
        @(negedge clk); lead_en_i = 1'b1; trail_en_i = 1'b1;

        // R6 / R7 / R9: one edge per cycle for 8 cycles
        check(ovf_o == 1'b0, "R6 ovf before burst", ovf_o, 0);
        set_len(1);
        base = got_n;
        d0 = drops;
        for (int k = 0; k < 8; k++) drive_seg(!mlvl, (k == 7) ? 40 : 1);
        repeat (40) @(negedge clk);
        kept = got_n - base;
        check(kept + (drops - d0) == 8, "R9 kept plus dropped", kept + drops - d0, 8);
        check(drops - d0 >= 1, "R6 drop pulses", drops - d0, 1);
        check(ovf_o == 1'b1, "R6 ovf after burst", ovf_o, 1);
        check(kept >= 5, "R7 write on full read cycle kept", kept, 5);
        for (int i = 0; i < 4; i++) begin
            check(got_r[base + i] == exp_r[base + i], "R9 burst polarity", got_r[base + i], exp_r[base + i]);
            check(got_t[base + i] == exp_t[base + i], "R8 burst timestamp", got_t[base + i], exp_t[base + i]);
        end
        exp_n = got_n;
        cmp_idx = got_n;

        // R6: flag stays set through normal traffic
        set_len(2);
        run_rand(10);
        compare_exact("R6 after overflow");
        check(ovf_o == 1'b1, "R6 ovf sticky", ovf_o, 1);

        do_reset();
        @(negedge clk);
        check(ovf_o == 1'b0, "R1 ovf cleared by reset", ovf_o, 0);
        set_len(4);
        run_rand(12);
        compare_exact("R1 after reset");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule